// File: doc/BRIEF.md
# Registered Programmable Logic Output Cell

This block models a single output cell of a sum-of-products programmable logic device. A small input bus and one feedback literal enter a set of product terms. Each term is an AND of literals chosen by static true and complement masks. Four general terms are ORed to form the cell's data value. Three dedicated terms drive the cell register's set, reset and clock, and a fourth term drives the output enable. The register value passes through a per-cell polarity inversion to a tri-state pin.

The cell can load its register from the value forced on its pin, which lets a test put any state, legal or not, straight into a state machine built from several cells. When both the set and reset terms have no literal connected, they are always HIGH. The cell then bypasses the register and drives the pin combinationally. Every configuration input is meant to be held constant while the cell runs. The product-term clock is sampled by the system clock `clk`, so every register update lands on a `clk` rising edge.

Top module: `pldMacrocell`

## Requirements
- R1: While `rstN` is LOW the register is cleared to 0, so in registered mode with set and reset terms inactive `pinOut` equals `cfgActiveLow` (HIGH for active-LOW polarity).
- R2: Literal bit k of a term is `inBus[k]` for k below IN_W and the feedback bit at index IN_W. A term is HIGH when every literal selected in `cfgTrue` is 1 and every literal selected in `cfgComp` is 0. A term with no literal selected is HIGH, and a term selecting both forms of one literal is LOW. The data value is the OR of the four general terms.
- R3: Term slices are packed LSB first as set (0), reset (1), clock (2), enable (3), then the general terms (4 to 7), each IN_W+1 bits wide. The register captures the data value at the first `clk` edge where the clock term is HIGH after having been LOW at the previous edge. It does not capture while the clock term stays HIGH.
- R4: In registered mode a HIGH set term drives the register state to 1 and a HIGH reset term drives it to 0. Either one shows at `pinOut` in the same cycle, without waiting for a clock edge. Set wins over reset, and both override the clock term.
- R5: While `preloadN` is LOW and set and reset are inactive, each `clk` edge loads `pinIn ^ cfgActiveLow` into the register, so the pin then reads the impressed level. Preload overrides the clock term.
- R6: When the set and reset terms both have no literal selected, `pinOut` follows the data value combinationally and ignores the clock term.
- R7: `pinOut` is the cell state XOR `cfgActiveLow`.
- R8: `pinOe` is HIGH only when the enable term is HIGH and `oeN` is LOW. A permanently LOW enable term makes the pin a pure input.
- R9: The feedback literal carries the register state in registered mode and `pinIn` in combinational mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the product-term clock and the preload |
| rstN | input | 1 | Asynchronous active-LOW power-up reset |
| inBus | input | IN_W | Dedicated array inputs |
| preloadN | input | 1 | Active-LOW preload control |
| oeN | input | 1 | Active-LOW external output enable |
| pinIn | input | 1 | Level present on the pin |
| cfgTrue | input | (NUM_SUM+4)*(IN_W+1) | True-literal select masks, one slice per term |
| cfgComp | input | (NUM_SUM+4)*(IN_W+1) | Complement-literal select masks, one slice per term |
| cfgActiveLow | input | 1 | Output polarity, 1 inverts |
| pinOut | output | 1 | Pin drive value |
| pinOe | output | 1 | Pin driver enable |

## Verification
A wrong register state shows at `pinOut` at the next sample, inverted when the polarity bit is set. In a feedback machine it also steers every later capture, so a single bad bit spreads through the whole state sequence from that edge on. A fault in set or reset priority appears in the same cycle the terms are driven. A fault in edge detection or preload appears one `clk` edge after the stimulus.

// File: rtl/pldCellPkg.sv
package pldCellPkg;
  // dedicated term positions inside the packed configuration masks
  localparam int PT_SET = 0;
  localparam int PT_RESET = 1;
  localparam int PT_CLOCK = 2;
  localparam int PT_ENABLE = 3;
  localparam int PT_FIRST_SUM = 4;

  typedef struct packed {
    logic forceHigh;
    logic forceLow;
    logic loadPin;
    logic capture;
  } cellStrobe_t;
endpackage

// File: rtl/pldTermArray.sv
module pldTermArray #(
  parameter int IN_W = 8,
  parameter int NUM_SUM = 4
) (
  input  logic [IN_W-1:0] inBus,
  input  logic fbBit,
  input  logic [(NUM_SUM+4)*(IN_W+1)-1:0] cfgTrue,
  input  logic [(NUM_SUM+4)*(IN_W+1)-1:0] cfgComp,
  output logic [3:0] ctlTerms,
  output logic sumData,
  output logic setEmpty,
  output logic resetEmpty
);
  import pldCellPkg::*;
  localparam int LIT_W = IN_W + 1;
  localparam int NUM_PT = NUM_SUM + 4;

  logic [LIT_W-1:0] lits;
  logic [NUM_PT-1:0] termVal;

  assign lits = {fbBit, inBus};

  for (genvar k = 0; k < NUM_PT; k++) begin : g_term
    logic [LIT_W-1:0] tSel;
    logic [LIT_W-1:0] cSel;
    assign tSel = cfgTrue[k*LIT_W +: LIT_W];
    assign cSel = cfgComp[k*LIT_W +: LIT_W];
    assign termVal[k] = &((~tSel | lits) & (~cSel | ~lits));
  end

  assign ctlTerms = termVal[PT_ENABLE:PT_SET];
  assign sumData = |termVal[NUM_PT-1:PT_FIRST_SUM];
  assign setEmpty = ~(|cfgTrue[PT_SET*LIT_W +: LIT_W]) & ~(|cfgComp[PT_SET*LIT_W +: LIT_W]);
  assign resetEmpty = ~(|cfgTrue[PT_RESET*LIT_W +: LIT_W]) & ~(|cfgComp[PT_RESET*LIT_W +: LIT_W]);
endmodule

// File: rtl/pldCellControl.sv
module pldCellControl (
  input  logic clk,
  input  logic rstN,
  input  logic setTerm,
  input  logic resetTerm,
  input  logic clkTerm,
  input  logic setEmpty,
  input  logic resetEmpty,
  input  logic preloadN,
  output pldCellPkg::cellStrobe_t strobe,
  output logic combMode
);
  logic clkPrev;

  // reset to 1 so a term already HIGH at release is not taken as an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b1;
    else clkPrev <= clkTerm;
  end

  assign combMode = setEmpty & resetEmpty;

  always_comb begin
    strobe.forceHigh = setTerm & ~combMode;
    strobe.forceLow = resetTerm & ~combMode;
    strobe.loadPin = ~preloadN;
    strobe.capture = clkTerm & ~clkPrev;
  end
endmodule

// File: rtl/pldCellDatapath.sv
module pldCellDatapath (
  input  logic clk,
  input  logic rstN,
  input  pldCellPkg::cellStrobe_t strobe,
  input  logic combMode,
  input  logic sumData,
  input  logic enableTerm,
  input  logic oeN,
  input  logic pinIn,
  input  logic cfgActiveLow,
  output logic pinOut,
  output logic pinOe,
  output logic fbBit,
  output logic regState
);
  logic effState;
  logic coreVal;

  // priority: set, reset, preload, product-term clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regState <= 1'b0;
    else if (strobe.forceHigh) regState <= 1'b1;
    else if (strobe.forceLow) regState <= 1'b0;
    else if (strobe.loadPin) regState <= pinIn ^ cfgActiveLow;
    else if (strobe.capture) regState <= sumData;
  end

  always_comb begin
    if (strobe.forceHigh) effState = 1'b1;
    else if (strobe.forceLow) effState = 1'b0;
    else effState = regState;
    coreVal = combMode ? sumData : effState;
  end

  assign pinOut = coreVal ^ cfgActiveLow;
  assign pinOe = enableTerm & ~oeN;
  // stored state only, so set/reset never form a loop through the array
  assign fbBit = combMode ? pinIn : regState;
endmodule

// File: rtl/pldMacrocell.sv
module pldMacrocell #(
  parameter int IN_W = 8,
  parameter int NUM_SUM = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic [IN_W-1:0] inBus,
  input  logic preloadN,
  input  logic oeN,
  input  logic pinIn,
  input  logic [(NUM_SUM+4)*(IN_W+1)-1:0] cfgTrue,
  input  logic [(NUM_SUM+4)*(IN_W+1)-1:0] cfgComp,
  input  logic cfgActiveLow,
  output logic pinOut,
  output logic pinOe
);
  import pldCellPkg::*;

  logic [3:0] ctlTerms;
  logic sumData;
  logic setEmpty;
  logic resetEmpty;
  logic fbBit;
  logic regState;
  logic combMode;
  logic setTerm;
  logic resetTerm;
  logic clkTerm;
  logic enableTerm;
  cellStrobe_t strobe;

  assign setTerm = ctlTerms[PT_SET];
  assign resetTerm = ctlTerms[PT_RESET];
  assign clkTerm = ctlTerms[PT_CLOCK];
  assign enableTerm = ctlTerms[PT_ENABLE];

  pldTermArray #(.IN_W(IN_W), .NUM_SUM(NUM_SUM)) array_i (
    .inBus(inBus), .fbBit(fbBit), .cfgTrue(cfgTrue), .cfgComp(cfgComp),
    .ctlTerms(ctlTerms), .sumData(sumData), .setEmpty(setEmpty), .resetEmpty(resetEmpty)
  );

  pldCellControl ctrl_i (
    .clk(clk), .rstN(rstN), .setTerm(setTerm), .resetTerm(resetTerm),
    .clkTerm(clkTerm), .setEmpty(setEmpty), .resetEmpty(resetEmpty),
    .preloadN(preloadN), .strobe(strobe), .combMode(combMode)
  );

  pldCellDatapath data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .combMode(combMode),
    .sumData(sumData), .enableTerm(enableTerm), .oeN(oeN), .pinIn(pinIn),
    .cfgActiveLow(cfgActiveLow), .pinOut(pinOut), .pinOe(pinOe),
    .fbBit(fbBit), .regState(regState)
  );
endmodule

// File: rtl/pldMacrocellChecker.sv
module pldMacrocellChecker (
  input logic clk,
  input logic rstN,
  input logic preloadN,
  input logic oeN,
  input logic pinIn,
  input logic cfgActiveLow,
  input logic pinOut,
  input logic pinOe,
  input logic setTerm,
  input logic resetTerm,
  input logic clkTerm,
  input logic enableTerm,
  input logic sumData,
  input logic combMode,
  input logic regState
);
  a_r1_cleared_at_release: assert property (@(posedge clk)
    $rose(rstN) |-> regState == 1'b0);

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (!combMode && setTerm) |-> pinOut == !cfgActiveLow);

  a_r4_reset_forces_low: assert property (@(posedge clk) disable iff (!rstN)
    (!combMode && !setTerm && resetTerm) |-> pinOut == cfgActiveLow);

  a_r5_preload_loads_pin: assert property (@(posedge clk) disable iff (!rstN)
    (!combMode && !preloadN && !setTerm && !resetTerm) |=> regState == $past(pinIn ^ cfgActiveLow));

  a_r3_capture_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (!combMode && preloadN && !setTerm && !resetTerm && $past(rstN) && clkTerm && !$past(clkTerm))
      |=> regState == $past(sumData));

  a_r6_bypass_follows_data: assert property (@(posedge clk) disable iff (!rstN)
    combMode |-> pinOut == (sumData ^ cfgActiveLow));

  a_r8_enable_needs_pin: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !pinOe);

  a_r8_enable_needs_term: assert property (@(posedge clk) disable iff (!rstN)
    !enableTerm |-> !pinOe);
endmodule

bind pldMacrocell pldMacrocellChecker chk_i (
  .clk(clk), .rstN(rstN), .preloadN(preloadN), .oeN(oeN), .pinIn(pinIn),
  .cfgActiveLow(cfgActiveLow), .pinOut(pinOut), .pinOe(pinOe),
  .setTerm(setTerm), .resetTerm(resetTerm), .clkTerm(clkTerm),
  .enableTerm(enableTerm), .sumData(sumData), .combMode(combMode),
  .regState(regState)
);

// File: tb/pldMacrocell_tb.sv
module pldMacrocell_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 8;
  localparam int NUM_SUM = 4;
  localparam int LIT_W = IN_W + 1;
  localparam int NUM_PT = NUM_SUM + 4;
  localparam int FB = IN_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IN_W-1:0] inBus = '0;
  logic preloadN = 1'b1;
  logic oeN = 1'b0;
  logic pinIn = 1'b0;
  logic [NUM_PT*LIT_W-1:0] cfgTrue = '0;
  logic [NUM_PT*LIT_W-1:0] cfgComp = '0;
  logic cfgActiveLow = 1'b1;
  logic pinOut;
  logic pinOe;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pldMacrocell #(.IN_W(IN_W), .NUM_SUM(NUM_SUM)) dut_i (
    .clk(clk), .rstN(rstN), .inBus(inBus), .preloadN(preloadN), .oeN(oeN),
    .pinIn(pinIn), .cfgTrue(cfgTrue), .cfgComp(cfgComp),
    .cfgActiveLow(cfgActiveLow), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic expectBit(string tag, logic act, logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cfgClear();
    cfgTrue = '0;
    cfgComp = '0;
  endtask

  task automatic useTrue(int t, int l);
    cfgTrue[t*LIT_W + l] = 1'b1;
  endtask

  task automatic useComp(int t, int l);
    cfgComp[t*LIT_W + l] = 1'b1;
  endtask

  task automatic killTerm(int t);
    useTrue(t, 0);
    useComp(t, 0);
  endtask

  // registered: set=in7, reset=in6, clock=in5, enable always, data=in0
  task automatic cfgRegistered();
    cfgClear();
    useTrue(0, 7);
    useTrue(1, 6);
    useTrue(2, 5);
    useTrue(4, 0);
    for (int t = 5; t < NUM_PT; t++) killTerm(t);
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    inBus = '0;
    preloadN = 1'b1;
    oeN = 1'b0;
    pinIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  // move to the next sampling point (just after a falling edge)
  task automatic nextSample();
    @(negedge clk);
    #1;
  endtask

  task automatic testPowerUp();
    cfgRegistered();
    cfgActiveLow = 1'b1;
    applyReset();
    expectBit("R1 power-up pin active-low", pinOut, 1'b1);
    expectBit("R8 enable after power-up", pinOe, 1'b1);
    nextSample();
    expectBit("R1 power-up state held", pinOut, 1'b1);
    cfgActiveLow = 1'b0;
    applyReset();
    expectBit("R7 power-up pin active-high", pinOut, 1'b0);
  endtask

  task automatic testClockCapture();
    cfgRegistered();
    cfgActiveLow = 1'b1;
    applyReset();
    inBus = 8'h01;
    nextSample();
    expectBit("R3 no capture while clock term low", pinOut, 1'b1);
    inBus = 8'h21;
    #1;
    expectBit("R3 no change before edge", pinOut, 1'b1);
    nextSample();
    expectBit("R3 captured 1 on rising term", pinOut, 1'b0);
    inBus = 8'h20;
    nextSample();
    expectBit("R3 no capture while term stays high", pinOut, 1'b0);
    inBus = 8'h00;
    nextSample();
    expectBit("R3 no capture on falling term", pinOut, 1'b0);
    inBus = 8'h20;
    nextSample();
    expectBit("R3 captured 0 on rising term", pinOut, 1'b1);
  endtask

  task automatic testSetReset();
    cfgRegistered();
    cfgActiveLow = 1'b1;
    applyReset();
    inBus = 8'h80;
    #1;
    expectBit("R4 set shows at once", pinOut, 1'b0);
    nextSample();
    inBus = 8'h00;
    #1;
    expectBit("R4 set state held", pinOut, 1'b0);
    inBus = 8'h40;
    #1;
    expectBit("R4 reset shows at once", pinOut, 1'b1);
    inBus = 8'hC0;
    #1;
    expectBit("R4 set wins over reset", pinOut, 1'b0);
    nextSample();
    inBus = 8'h00;
    nextSample();
    inBus = 8'hE0;
    nextSample();
    expectBit("R4 set overrides clock capture of 0", pinOut, 1'b0);
    inBus = 8'h00;
    nextSample();
    inBus = 8'h61;
    nextSample();
    expectBit("R4 reset overrides clock capture of 1", pinOut, 1'b1);
    inBus = 8'h01;
    nextSample();
    expectBit("R4 state kept after release", pinOut, 1'b1);
  endtask

  task automatic testPreload();
    cfgRegistered();
    cfgActiveLow = 1'b1;
    applyReset();
    preloadN = 1'b0;
    pinIn = 1'b0;
    inBus = 8'h20;
    nextSample();
    preloadN = 1'b1;
    #1;
    expectBit("R5 preload LOW beats clock", pinOut, 1'b0);
    preloadN = 1'b0;
    pinIn = 1'b1;
    nextSample();
    preloadN = 1'b1;
    #1;
    expectBit("R5 preload HIGH", pinOut, 1'b1);
    nextSample();
    expectBit("R5 preloaded state held", pinOut, 1'b1);
  endtask

  // data = NOT feedback: a toggle started from a preloaded state
  task automatic testFeedbackToggle();
    cfgClear();
    useTrue(0, 7);
    useTrue(1, 6);
    useTrue(2, 5);
    useComp(4, FB);
    for (int t = 5; t < NUM_PT; t++) killTerm(t);
    cfgActiveLow = 1'b0;
    applyReset();
    expectBit("R9 toggle starts low", pinOut, 1'b0);
    preloadN = 1'b0;
    pinIn = 1'b1;
    nextSample();
    preloadN = 1'b1;
    pinIn = 1'b0;
    #1;
    expectBit("R5 preload into toggle", pinOut, 1'b1);
    inBus = 8'h20;
    nextSample();
    expectBit("R9 toggle from preloaded 1", pinOut, 1'b0);
    inBus = 8'h00;
    nextSample();
    inBus = 8'h20;
    nextSample();
    expectBit("R9 toggle back to 1", pinOut, 1'b1);
    inBus = 8'h00;
    nextSample();
    inBus = 8'h20;
    nextSample();
    expectBit("R9 toggle to 0 again", pinOut, 1'b0);
  endtask

  // combinational: data = in0 | in1&in2 | in3&~in4
  task automatic testBypass();
    logic [IN_W-1:0] pat [7] = '{8'h00, 8'h01, 8'h02, 8'h06, 8'h08, 8'h18, 8'h10};
    logic expD [7] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    cfgClear();
    useTrue(2, 5);
    useTrue(4, 0);
    useTrue(5, 1);
    useTrue(5, 2);
    useTrue(6, 3);
    useComp(6, 4);
    killTerm(7);
    cfgActiveLow = 1'b0;
    applyReset();
    for (int i = 0; i < 7; i++) begin
      inBus = pat[i];
      #1;
      expectBit($sformatf("R2 R6 data pattern %0d", i), pinOut, expD[i]);
    end
    inBus = 8'h26;
    #1;
    expectBit("R6 clock term ignored", pinOut, 1'b1);
    nextSample();
    inBus = 8'h20;
    #1;
    expectBit("R6 no register hold", pinOut, 1'b0);
    cfgActiveLow = 1'b1;
    inBus = 8'h06;
    #1;
    expectBit("R7 inverted combinational", pinOut, 1'b0);
  endtask

  task automatic testEnableAndInput();
    cfgClear();
    useTrue(3, 2);
    useTrue(4, FB);
    for (int t = 5; t < NUM_PT; t++) killTerm(t);
    cfgActiveLow = 1'b0;
    applyReset();
    oeN = 1'b0;
    inBus = 8'h04;
    #1;
    expectBit("R8 term high pin low enables", pinOe, 1'b1);
    inBus = 8'h00;
    #1;
    expectBit("R8 term low disables", pinOe, 1'b0);
    oeN = 1'b1;
    inBus = 8'h04;
    #1;
    expectBit("R8 pin high disables", pinOe, 1'b0);
    oeN = 1'b0;
    killTerm(3);
    #1;
    expectBit("R8 dead term makes input", pinOe, 1'b0);
    pinIn = 1'b1;
    #1;
    expectBit("R9 pin fed back high", pinOut, 1'b1);
    pinIn = 1'b0;
    #1;
    expectBit("R9 pin fed back low", pinOut, 1'b0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    @(negedge clk);
    testPowerUp();
    testClockCapture();
    testSetReset();
    testPreload();
    testFeedbackToggle();
    testBypass();
    testEnableAndInput();
    finish();
  end
endmodule